// File: doc/BRIEF.md
# Sequential Fractional Ratio Divider

This block computes the fractional part of a ratio: given a numerator `a` and a larger denominator `b`, it produces `f = floor(a * 2^n / b)`. It produces one quotient bit per clock through a restoring long-division step. In each step the running remainder is doubled, then compared with the denominator, and the denominator is subtracted from it when it fits. The compare and the subtract form one conditional-subtract operation.

A typical use is to derive an oscillator tuning word. With `a` as the wanted output frequency, `b` as the clock frequency and `n = 32`, the result is the increment that a 32-bit phase accumulator needs to produce that output frequency.

The operands and the bit count are captured on a one-cycle `start` pulse while the block is idle. `busy` stays high while bits are being produced. A one-cycle `done` pulse marks the point where `quot` holds the result. `quot` keeps that value until the next accepted start. The integer part of the ratio, signed operands and rounding are not handled. Operands that break `a < b <= 2^31` give undefined quotients.

Top module: `frac_ratio_div`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `quot` is 0.
- R2: A `start` sampled while idle captures `num`, `den` and `nbits`. When `nbits` is nonzero, `busy` is 1 from the next cycle until `done` rises, and `busy` and `done` are never 1 together.
- R3: For `num < den <= 2^31` and `nbits` in 1..32, `quot` at `done` equals `floor(num * 2^nbits / den)`. Bit 0 of `quot` is the last quotient bit produced.
- R4: When `nbits = n` (n ≥ 1), `done` is 1 in the cycle that follows the n-th clock edge after the edge that sampled `start`. One quotient bit is produced per edge in between.
- R5: `done` is high for exactly one cycle. After it, `quot` holds its value while no new start is accepted.
- R6: A start with `nbits = 0` raises `done` in the next cycle with `quot = 0`, and `busy` stays 0.
- R7: A `start` pulse while `busy` is 1 is ignored. The running division keeps its operands, its result and its timing.
- R8: The doubled remainder is compared in WIDTH+1 bits. A remainder that doubles to 2^32 - 2 therefore still gives correct quotient bits, for example `num = 2^31 - 1` and `den = 2^31` giving `0xFFFFFFFE`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a division |
| num | input | WIDTH | Numerator `a`, must be below `den` |
| den | input | WIDTH | Denominator `b`, at most 2^(WIDTH-1) |
| nbits | input | $clog2(WIDTH+1) | Number of quotient bits to produce, 0..WIDTH |
| quot | output | WIDTH | Fractional quotient, valid from `done` until the next start |
| busy | output | 1 | High while quotient bits are being produced |
| done | output | 1 | One-cycle pulse when `quot` is valid |

## Verification
The remainder assertion assumes that every accepted start carries `num < den` and `den <= 2^31`. Under that condition each conditional subtract leaves the remainder below the denominator. The counting assertions assume that `nbits` never exceeds WIDTH.

Every vector in the stimulus table, and every directed case, is chosen within these limits. This includes the extremes: `den = 2^31`, with `num` one below it and with `num = 1`. A start pulse that arrives during a run uses operands that also meet the limits, so the run it must not disturb stays comparable.

// File: rtl/frd_pkg.sv
package frd_pkg;
    // width of a counter able to hold the values 0..w
    function automatic int cnt_width(input int w);
        return $clog2(w + 1);
    endfunction
endpackage

// File: rtl/frd_step.sv
module frd_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] rem_i,
    input  logic [WIDTH-1:0] acc_i,
    input  logic [WIDTH-1:0] dvs_i,
    output logic [WIDTH-1:0] rem_o,
    output logic [WIDTH-1:0] acc_o
);
    logic [WIDTH:0]   dbl;
    logic             fits;
    logic [WIDTH-1:0] diff;

    always_comb begin
        dbl   = {rem_i, 1'b0};
        fits  = (dbl >= {1'b0, dvs_i});
        diff  = dbl[WIDTH-1:0] - dvs_i;
        rem_o = fits ? diff : dbl[WIDTH-1:0];
        acc_o = {acc_i[WIDTH-2:0], fits};
    end

    // R8: once a bit is taken, the new remainder is below the divisor
    always_comb begin
        if (fits && (rem_i < dvs_i))
            assert_step_rem_low_R8: assert (rem_o < dvs_i);
    end
endmodule

// File: rtl/frd_ctrl.sv
module frd_ctrl #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] nbits,
    output logic             load,
    output logic             step,
    output logic             busy,
    output logic             done
);
    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end else if (start) begin
            st_d.cnt = nbits;
            if (nbits == '0) st_d.done = 1'b1;
            else             st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load = start && !st_q.busy;
    assign step = st_q.busy;
    assign busy = st_q.busy;
    assign done = st_q.done;

    assert_busy_done_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.busy && st_q.done));
    assert_busy_cnt_nz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.cnt != '0));
    assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);
    assert_zero_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !st_q.busy && nbits == '0) |=> (st_q.done && !st_q.busy));
endmodule

// File: rtl/frac_ratio_div.sv
module frac_ratio_div #(
    parameter int WIDTH = 32,
    localparam int CNT_W = frd_pkg::cnt_width(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] num,
    input  logic [WIDTH-1:0] den,
    input  logic [CNT_W-1:0] nbits,
    output logic [WIDTH-1:0] quot,
    output logic             busy,
    output logic             done
);
    typedef struct packed {
        logic [WIDTH-1:0] rem;
        logic [WIDTH-1:0] dvs;
        logic [WIDTH-1:0] acc;
    } dp_t;

    dp_t              dp_d, dp_q;
    logic             load, step;
    logic [WIDTH-1:0] rem_nx, acc_nx;

    frd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .nbits (nbits),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    frd_step #(.WIDTH(WIDTH)) u_step (
        .rem_i (dp_q.rem),
        .acc_i (dp_q.acc),
        .dvs_i (dp_q.dvs),
        .rem_o (rem_nx),
        .acc_o (acc_nx)
    );

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            dp_d.rem = num;
            dp_d.dvs = den;
            dp_d.acc = '0;
        end else if (step) begin
            dp_d.rem = rem_nx;
            dp_d.acc = acc_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign quot = dp_q.acc;

    // R8: with legal operands the remainder stays below the divisor during a run
    assert_rem_below_den_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (dp_q.rem < dp_q.dvs));
    assert_ignore_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(dp_q.dvs));
    assert_quot_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(quot));
endmodule

// File: tb/frac_ratio_div_tb.sv
module frac_ratio_div_tb;
    localparam int W  = 32;
    localparam int CW = 6;

    typedef struct packed {
        logic [W-1:0]  a;
        logic [W-1:0]  b;
        logic [CW-1:0] n;
        logic [W-1:0]  f;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'd1,          32'd2,          6'd32, 32'h8000_0000},
        '{32'd1,          32'd4,          6'd32, 32'h4000_0000},
        '{32'd5_000_000,  32'd80_000_000, 6'd32, 32'h1000_0000},
        '{32'd1,          32'd3,          6'd32, 32'h5555_5555},
        '{32'd2,          32'd3,          6'd8,  32'h0000_00AA},
        '{32'h7FFF_FFFF,  32'h8000_0000,  6'd32, 32'hFFFF_FFFE},
        '{32'd1,          32'h8000_0000,  6'd32, 32'h0000_0002},
        '{32'd7,          32'd10,         6'd16, 32'h0000_B333},
        '{32'd3,          32'd7,          6'd1,  32'h0000_0000},
        '{32'd4,          32'd7,          6'd1,  32'h0000_0001}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  num = '0;
    logic [W-1:0]  den = '0;
    logic [CW-1:0] nbits = '0;
    logic [W-1:0]  quot;
    logic          busy, done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    frac_ratio_div #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .num(num), .den(den),
        .nbits(nbits), .quot(quot), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs one division; optionally pulses start with other operands at cycle ign_at.
    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input logic [CW-1:0] n,
                       input logic [W-1:0] f, input int ign_at);
        int  lat = 0;
        bit  busy_ok = 1'b1;
        logic [W-1:0] held;
        @(negedge clk);
        num = a; den = b; nbits = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (n != 0) check(busy == 1'b1, "R2 busy after start", {63'd0, busy}, 64'd1);
        while (!done && lat < 100) begin
            if (!busy) busy_ok = 1'b0;
            if (lat == ign_at) begin
                num = 32'd1; den = 32'd2; nbits = 6'd5; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        if (n == 0) check(busy == 1'b0, "R6 busy stays low", {63'd0, busy}, 64'd0);
        else        check(busy_ok && !busy, "R2 busy until done", {63'd0, busy_ok}, 64'd1);
        check(lat == int'(n), (ign_at >= 0) ? "R7 latency kept" : "R4 latency", lat, n);
        check(quot == f, (ign_at >= 0) ? "R7 result kept" : "R3 quotient", quot, f);
        held = quot;
        @(negedge clk);
        check(!done, "R5 done one cycle", {63'd0, done}, 64'd0);
        repeat (3) @(negedge clk);
        check(quot == held, "R5 quot held", quot, held);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 1'b0 && done == 1'b0, "R1 flags at reset", {62'd0, busy, done}, 64'd0);
        check(quot == '0, "R1 quot at reset", quot, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3/R4 table walk; vector 5 is the R8 wide-compare case
        for (int i = 0; i < NV; i++) begin
            if (i == 5) $display("vector %0d exercises R8", i);
            run(VECS[i].a, VECS[i].b, VECS[i].n, VECS[i].f, -1);
        end

        // R6 zero bit count
        run(32'd3, 32'd5, 6'd0, 32'd0, -1);

        // R8 largest doubled remainder, short run
        run(32'h7FFF_FFFF, 32'h8000_0000, 6'd4, 32'h0000_000F, -1);

        // R7 start during a run is ignored
        run(32'd1, 32'd3, 6'd32, 32'h5555_5555, 7);
        run(32'd2, 32'd3, 6'd8, 32'h0000_00AA, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule